// File: doc/BRIEF.md
# Double-Buffered Synthesizer Divider Programming Port

This block holds the divider settings of an integer-N frequency synthesizer: a 6-bit reference divide value, a 9-bit main divide value, a 4-bit swallow count and a prescaler-bypass flag. Settings arrive through one of three loading paths. The first is a serial shift port, MSB first. The second is a byte-wide bus with three field write strobes. The third is a set of direct pins. The settings are held in a 20-bit primary word and a 20-bit secondary (hop) word.

A select input chooses which of the two words drives the divider outputs. The system can therefore prepare the next channel while the current one keeps running, and then switch between them in one step.

An 8-bit control register supplies the power-down, continuous-load, test-output and monitor-disable controls. It can be written from the bus. It can also be shifted in serially, in which case a shadow stage keeps the new bits inactive until the control write line falls. Every strobe and the serial clock are asynchronous to the system clock. Each is synchronized and edge-detected, so every register update is a single-cycle event in the `clk_i` domain.

Top module: `pll_prog_if`

## Requirements
- R1: The mode is decoded from two pins. `bus_mode_i`=1 selects direct mode. `bus_mode_i`=0 with `ser_mode_i`=1 selects serial mode. `bus_mode_i`=0 with `ser_mode_i`=0 selects parallel mode.
- R2: In serial mode, while `swr_i` and `ewr_i` are both low, each rising `sclk_i` shifts `sdata_i` into a 20-bit setting shifter, MSB first. The 20-bit word layout is:
  - bits [19:18] hold R[5:4]
  - bits [17:16] hold M[8:7]
  - bit 15 holds the prescaler bypass
  - bits [14:8] hold M[6:0]
  - bits [7:4] hold R[3:0]
  - bits [3:0] hold A
- R3: In serial mode, a rising `swr_i` acts on the bits shifted since the previous rising `swr_i`.
  - If at least 20 bits arrived, the last 20 are loaded into both the primary and the secondary word.
  - If fewer arrived, they are discarded, the primary word is unchanged, and the secondary word takes a copy of the primary.
- R4: In parallel mode, `pdata_i` is written into the primary word by three strobes:
  - a rising `m1_wr_i` writes `pdata_i[7:0]` to {bypass, M[6:0]}
  - a rising `m2_wr_i` writes `pdata_i[3:0]` to {R[5:4], M[8:7]}
  - a rising `a_wr_i` writes `pdata_i[7:0]` to {R[3:0], A}
- R5: In serial or parallel mode, a rising `hop_wr_i` copies the primary word into the secondary word. No other event changes the secondary word, apart from a rising `swr_i` in serial mode.
- R6: Outside direct mode, `fsel_i`=1 drives the outputs from the primary word and `fsel_i`=0 drives them from the secondary word.
- R7: In direct mode, the outputs come from the direct pins. R[5:4] and M[8:7] read zero.
- R8: Field strobes have no effect outside parallel mode. Serial clock edges and `swr_i` have no effect outside serial mode.
- R9: In serial mode, while `ewr_i` is high and `swr_i` is low, rising `sclk_i` edges shift `sdata_i` into an 8-bit control shifter, MSB first. The shifted bits become active only on the falling edge of `ewr_i`.
- R10: In parallel mode, a rising `ewr_i` loads `pdata_i` into the active control register. A falling `ewr_i` in parallel mode changes nothing.
- R11: The control outputs are active only while `enh_n_i` is low and the block is not in direct mode. The bit assignments are:
  - bit 3 drives `pwr_dn_o`
  - bit 4 drives `cnt_load_o`
  - bit 5 drives `msel_tst_o`
  - bit 6 drives `pre_tst_o`
  - bit 7 drives `mon_off_o`
  - bits 0 to 2 are stored but drive nothing
- R12: Reset clears the primary word, the secondary word, both shifters, the bit count and the control register. All outputs therefore read zero after reset outside direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_mode_i | input | 1 | Direct mode select |
| ser_mode_i | input | 1 | Serial (1) or parallel (0) when not direct |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data, MSB first |
| swr_i | input | 1 | Serial commit strobe |
| ewr_i | input | 1 | Control register write line |
| m1_wr_i | input | 1 | Strobe for bypass and M[6:0] |
| m2_wr_i | input | 1 | Strobe for R[5:4] and M[8:7] |
| a_wr_i | input | 1 | Strobe for R[3:0] and A |
| hop_wr_i | input | 1 | Copy primary into secondary |
| pdata_i | input | 8 | Parallel data byte |
| fsel_i | input | 1 | Output source: 1 primary, 0 secondary |
| enh_n_i | input | 1 | Control bits enable, active low |
| dir_byp_i | input | 1 | Direct prescaler bypass |
| dir_m_i | input | 7 | Direct M[6:0] |
| dir_r_i | input | 4 | Direct R[3:0] |
| dir_a_i | input | 4 | Direct A |
| r_o | output | 6 | Reference divide value |
| m_o | output | 9 | Main divide value |
| a_o | output | 4 | Swallow count |
| byp_o | output | 1 | Prescaler bypass |
| pwr_dn_o | output | 1 | Power-down control |
| cnt_load_o | output | 1 | Continuous counter load control |
| msel_tst_o | output | 1 | Route modulus select to test output |
| pre_tst_o | output | 1 | Route raw prescaler output to test output |
| mon_off_o | output | 1 | Disable divider monitor outputs |

## Verification
A pin change is caught by the first rising clock edge and needs two synchronizer stages and one edge register. The register it updates therefore changes on the third rising edge after the change, and the combinational output follows that edge directly. Mode, select and enable pins feed the outputs combinationally. The bench changes every input on a falling clock edge and then waits four falling edges before it samples or drives again. This places each check after the third rising edge, keeps every strobe pulse long enough to be seen, and spaces the serial clock edges far enough apart that no edge is merged with the next. The control shadow is sampled both between the last shift and the falling write line, and after that fall.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
  localparam int WORD_W  = 20;
  localparam int BYTE_W  = 8;
  localparam int ENH_W   = 8;
  localparam int R_W     = 6;
  localparam int M_W     = 9;
  localparam int A_W     = 4;

  // setting word field positions (serial shift order depends on these)
  localparam int F_A_LO   = 0;
  localparam int F_RL_LO  = 4;
  localparam int F_ML_LO  = 8;
  localparam int F_BYP    = 15;
  localparam int F_MH_LO  = 16;
  localparam int F_RH_LO  = 18;

  // parallel strobe targets
  localparam int M1_LO = 8;
  localparam int M2_LO = 16;
  localparam int M2_W  = 4;
  localparam int AW_LO = 0;

  // control bits
  localparam int E_PWR  = 3;
  localparam int E_LOAD = 4;
  localparam int E_MSEL = 5;
  localparam int E_PRE  = 6;
  localparam int E_MON  = 7;

  // synchronized input lanes
  localparam int S_SCLK = 0;
  localparam int S_SDAT = 1;
  localparam int S_SWR  = 2;
  localparam int S_EWR  = 3;
  localparam int S_M1   = 4;
  localparam int S_M2   = 5;
  localparam int S_AW   = 6;
  localparam int S_HOP  = 7;
  localparam int S_N    = 8;

  typedef enum logic [1:0] {MODE_PAR = 2'd0, MODE_SER = 2'd1, MODE_DIR = 2'd2} mode_e;
endpackage

// File: rtl/pll_prog_sync.sv
module pll_prog_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pll_prog_serial.sv
module pll_prog_serial
  import pll_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_rise_i,
  input  logic              sdata_i,
  input  logic              swr_lvl_i,
  input  logic              ewr_lvl_i,
  input  logic              swr_rise_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o,
  output logic [ENH_W-1:0]  enh_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [ENH_W-1:0]  esh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              shift_w, shift_e;

  assign shift_w = en_i & sclk_rise_i & ~swr_lvl_i & ~ewr_lvl_i;
  assign shift_e = en_i & sclk_rise_i & ~swr_lvl_i &  ewr_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      esh_q <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_w) sh_q <= {sh_q[WORD_W-2:0], sdata_i};
      if (shift_e) esh_q <= {esh_q[ENH_W-2:0], sdata_i};
      if (en_i && swr_rise_i) cnt_q <= '0;
      else if (shift_w && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = sh_q;
  assign full_o = (cnt_q == CNT_MAX);
  assign enh_o  = esh_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && swr_rise_i) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/pll_prog_enh.sv
module pll_prog_enh
  import pll_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              par_i,
  input  logic              ewr_rise_i,
  input  logic              ewr_fall_i,
  input  logic [ENH_W-1:0]  ser_word_i,
  input  logic [BYTE_W-1:0] pdata_i,
  output logic [ENH_W-1:0]  act_o
);
  logic [ENH_W-1:0] act_q;
  logic             ld_ser, ld_par;

  assign ld_ser = ser_i & ewr_fall_i;
  assign ld_par = par_i & ewr_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (ld_ser) act_q <= ser_word_i;
    else if (ld_par) act_q <= ENH_W'(pdata_i);
  end

  assign act_o = act_q;

  AST_ENH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_ser || ld_par) |=> $stable(act_q)); // R9
  AST_ENH_PAR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_i && ewr_fall_i && !ewr_rise_i) |=> $stable(act_q)); // R10
endmodule

// File: rtl/pll_prog_if.sv
module pll_prog_if
  import pll_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_mode_i,
  input  logic              ser_mode_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              swr_i,
  input  logic              ewr_i,
  input  logic              m1_wr_i,
  input  logic              m2_wr_i,
  input  logic              a_wr_i,
  input  logic              hop_wr_i,
  input  logic [BYTE_W-1:0] pdata_i,
  input  logic              fsel_i,
  input  logic              enh_n_i,
  input  logic              dir_byp_i,
  input  logic [6:0]        dir_m_i,
  input  logic [3:0]        dir_r_i,
  input  logic [A_W-1:0]    dir_a_i,
  output logic [R_W-1:0]    r_o,
  output logic [M_W-1:0]    m_o,
  output logic [A_W-1:0]    a_o,
  output logic              byp_o,
  output logic              pwr_dn_o,
  output logic              cnt_load_o,
  output logic              msel_tst_o,
  output logic              pre_tst_o,
  output logic              mon_off_o
);
  mode_e             mode;
  logic              is_ser, is_par, is_dir;
  logic [S_N-1:0]    s_lvl, s_rise, s_fall;
  logic [WORD_W-1:0] pri_q, sec_q, ser_word, out_w;
  logic [ENH_W-1:0]  ser_enh, enh_act;
  logic              ser_full, pri_evt, sec_evt, commit, enh_on;

  always_comb begin
    if (bus_mode_i)      mode = MODE_DIR;
    else if (ser_mode_i) mode = MODE_SER;
    else                 mode = MODE_PAR;
  end
  assign is_dir = (mode == MODE_DIR);
  assign is_ser = (mode == MODE_SER);
  assign is_par = (mode == MODE_PAR);

  pll_prog_sync #(.W(S_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({hop_wr_i, a_wr_i, m2_wr_i, m1_wr_i, ewr_i, swr_i, sdata_i, sclk_i}),
    .lvl_o  (s_lvl),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  pll_prog_serial i_serial (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (is_ser),
    .sclk_rise_i(s_rise[S_SCLK]),
    .sdata_i    (s_lvl[S_SDAT]),
    .swr_lvl_i  (s_lvl[S_SWR]),
    .ewr_lvl_i  (s_lvl[S_EWR]),
    .swr_rise_i (s_rise[S_SWR]),
    .word_o     (ser_word),
    .full_o     (ser_full),
    .enh_o      (ser_enh)
  );

  pll_prog_enh i_enh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (is_ser),
    .par_i     (is_par),
    .ewr_rise_i(s_rise[S_EWR]),
    .ewr_fall_i(s_fall[S_EWR]),
    .ser_word_i(ser_enh),
    .pdata_i   (pdata_i),
    .act_o     (enh_act)
  );

  assign commit  = is_ser & s_rise[S_SWR];
  assign pri_evt = (is_par & (s_rise[S_M1] | s_rise[S_M2] | s_rise[S_AW])) | (commit & ser_full);
  assign sec_evt = commit | (~is_dir & s_rise[S_HOP]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= '0;
    end else if (commit && ser_full) begin
      pri_q <= ser_word;
    end else if (is_par) begin
      if (s_rise[S_M1]) pri_q[M1_LO +: BYTE_W] <= pdata_i;
      if (s_rise[S_M2]) pri_q[M2_LO +: M2_W]   <= pdata_i[M2_W-1:0];
      if (s_rise[S_AW]) pri_q[AW_LO +: BYTE_W] <= pdata_i;
    end
  end

  // a short serial word is dropped; the commit still copies primary across
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sec_q <= '0;
    else if (commit)                  sec_q <= ser_full ? ser_word : pri_q;
    else if (~is_dir & s_rise[S_HOP]) sec_q <= pri_q;
  end

  always_comb begin
    if (is_dir)      out_w = {4'b0, dir_byp_i, dir_m_i, dir_r_i, dir_a_i};
    else if (fsel_i) out_w = pri_q;
    else             out_w = sec_q;
  end

  assign r_o   = {out_w[F_RH_LO +: 2], out_w[F_RL_LO +: 4]};
  assign m_o   = {out_w[F_MH_LO +: 2], out_w[F_ML_LO +: 7]};
  assign a_o   = out_w[F_A_LO +: A_W];
  assign byp_o = out_w[F_BYP];

  assign enh_on     = ~enh_n_i & ~is_dir;
  assign pwr_dn_o   = enh_on & enh_act[E_PWR];
  assign cnt_load_o = enh_on & enh_act[E_LOAD];
  assign msel_tst_o = enh_on & enh_act[E_MSEL];
  assign pre_tst_o  = enh_on & enh_act[E_PRE];
  assign mon_off_o  = enh_on & enh_act[E_MON];

  AST_PRI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pri_evt |=> $stable(pri_q)); // R4
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_evt |=> $stable(sec_q)); // R5
  AST_SHORT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !ser_full) |=> $stable(pri_q)); // R3
  AST_DIR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_dir && $stable(is_dir)) |=> ($stable(pri_q) && $stable(sec_q))); // R8
endmodule

// File: tb/test_pll_prog_if.sv
module test_pll_prog_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       bmode = 1'b0, smode = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [5:0] strb = '0; // 0 swr,1 ewr,2 m1,3 m2,4 a,5 hop
  logic [7:0] pdata = '0;
  logic       fsel = 1'b0, enh_n = 1'b0, dbyp = 1'b0;
  logic [6:0] dm = '0;
  logic [3:0] dr = '0, da = '0;
  logic [5:0] r_o;
  logic [8:0] m_o;
  logic [3:0] a_o;
  logic       byp_o, pwr_o, load_o, msel_o, pre_o, mon_o;

  int checks = 0;
  int errors = 0;

  pll_prog_if i_pll_prog_if (
    .clk_i(clk), .rst_ni(rst_n), .bus_mode_i(bmode), .ser_mode_i(smode),
    .sclk_i(sclk), .sdata_i(sdata), .swr_i(strb[0]), .ewr_i(strb[1]),
    .m1_wr_i(strb[2]), .m2_wr_i(strb[3]), .a_wr_i(strb[4]), .hop_wr_i(strb[5]),
    .pdata_i(pdata), .fsel_i(fsel), .enh_n_i(enh_n), .dir_byp_i(dbyp),
    .dir_m_i(dm), .dir_r_i(dr), .dir_a_i(da),
    .r_o(r_o), .m_o(m_o), .a_o(a_o), .byp_o(byp_o), .pwr_dn_o(pwr_o),
    .cnt_load_o(load_o), .msel_tst_o(msel_o), .pre_tst_o(pre_o), .mon_off_o(mon_o)
  );

  // {m2 byte, m1 byte, a byte, exp r, exp m, exp a, exp bypass}
  localparam logic [43:0] VEC [4] = '{
    {8'h0F, 8'h80, 8'h00, 6'h30, 9'h180, 4'h0, 1'b1},
    {8'h02, 8'h55, 8'hA3, 6'h0A, 9'h155, 4'h3, 1'b0},
    {8'h05, 8'h7F, 8'h6C, 6'h16, 9'h0FF, 4'hC, 1'b0},
    {8'h0A, 8'hC1, 8'hF1, 6'h2F, 9'h141, 4'h1, 1'b1}
  };

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_f(input string tag, input logic [5:0] r, input logic [8:0] m,
                       input logic [3:0] a, input logic b);
    chk({tag, " r"}, 32'(r_o), 32'(r));
    chk({tag, " m"}, 32'(m_o), 32'(m));
    chk({tag, " a"}, 32'(a_o), 32'(a));
    chk({tag, " byp"}, 32'(byp_o), 32'(b));
  endtask

  // field map of a 20-bit setting word
  task automatic chk_w(input string tag, input logic [19:0] w);
    chk_f(tag, {w[19:18], w[7:4]}, {w[17:16], w[14:8]}, w[3:0], w[15]);
  endtask

  task automatic chk_enh(input string tag, input logic [4:0] e); // {mon,pre,msel,load,pwr}
    chk(tag, 32'({mon_o, pre_o, msel_o, load_o, pwr_o}), 32'(e));
  endtask

  task automatic pulse(input int idx);
    strb[idx] = 1'b1; settle();
    strb[idx] = 1'b0; settle();
  endtask

  task automatic par_wr(input int idx, input logic [7:0] d);
    pdata = d; settle();
    pulse(idx);
  endtask

  task automatic ser_send(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = val[i]; settle();
      sclk = 1'b1; settle();
      sclk = 1'b0; settle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] pr;
    logic [8:0] pm;
    logic [3:0] pa;
    logic       pb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R12: everything zero after reset (parallel mode, secondary selected)
    chk_f("R12 reset sec", 6'h0, 9'h0, 4'h0, 1'b0);
    fsel = 1'b1; settle();
    chk_f("R12 reset pri", 6'h0, 9'h0, 4'h0, 1'b0);
    chk_enh("R12 reset enh", 5'b0);

    // R1 R4 R5 R6: parallel vector table
    pr = '0; pm = '0; pa = '0; pb = 1'b0;
    for (int v = 0; v < 4; v++) begin
      fsel = 1'b1;
      par_wr(3, VEC[v][43:36]);
      par_wr(2, VEC[v][35:28]);
      par_wr(4, VEC[v][27:20]);
      chk_f("R4 R6 par pri", VEC[v][19:14], VEC[v][13:5], VEC[v][4:1], VEC[v][0]);
      fsel = 1'b0; settle();
      chk_f("R5 sec before hop", pr, pm, pa, pb);
      pulse(5);
      chk_f("R5 sec after hop", VEC[v][19:14], VEC[v][13:5], VEC[v][4:1], VEC[v][0]);
      pr = VEC[v][19:14]; pm = VEC[v][13:5]; pa = VEC[v][4:1]; pb = VEC[v][0];
    end

    // R1 R7: direct mode, upper bits forced low although stored words have them set
    bmode = 1'b1; dbyp = 1'b1; dm = 7'h5A; dr = 4'h9; da = 4'h6; fsel = 1'b1;
    settle();
    chk_f("R7 direct", 6'h09, 9'h05A, 4'h6, 1'b1);
    pulse(2); pulse(5);
    bmode = 1'b0; settle();
    chk_f("R8 direct strobes ignored", 6'h2F, 9'h141, 4'h1, 1'b1);

    // primary=V0, secondary=V3
    par_wr(3, VEC[0][43:36]);
    par_wr(2, VEC[0][35:28]);
    par_wr(4, VEC[0][27:20]);

    // R3: short serial word discarded, secondary takes primary
    smode = 1'b1; settle();
    ser_send(32'hFFF, 12);
    pulse(0);
    fsel = 1'b1; settle();
    chk_f("R3 short pri kept", VEC[0][19:14], VEC[0][13:5], VEC[0][4:1], VEC[0][0]);
    fsel = 1'b0; settle();
    chk_f("R3 short sec copy", VEC[0][19:14], VEC[0][13:5], VEC[0][4:1], VEC[0][0]);

    // R2 R3: full word into both
    ser_send(32'hA5C3E, 20);
    fsel = 1'b1; settle();
    chk_f("R3 pri before commit", VEC[0][19:14], VEC[0][13:5], VEC[0][4:1], VEC[0][0]);
    pulse(0);
    chk_w("R2 serial pri", 20'hA5C3E);
    fsel = 1'b0; settle();
    chk_w("R3 serial sec", 20'hA5C3E);

    // R3: 22 bits, last 20 kept
    ser_send(32'h331234, 22);
    pulse(0);
    chk_w("R3 overlong sec", 20'h31234);
    fsel = 1'b1; settle();
    chk_w("R3 overlong pri", 20'h31234);

    // R8: field strobe in serial mode ignored
    par_wr(2, 8'hFF);
    par_wr(4, 8'hFF);
    chk_w("R8 serial strobe ignored", 20'h31234);

    // R9 R11: serial control shift, shadowed until ewr falls
    strb[1] = 1'b1; settle();
    ser_send(32'hF8, 8);
    chk_enh("R9 hidden before fall", 5'b0);
    strb[1] = 1'b0; settle();
    chk_enh("R9 active after fall", 5'b11111);
    chk_w("R9 setting untouched", 20'h31234);
    enh_n = 1'b1; settle();
    chk_enh("R11 enable high", 5'b0);
    enh_n = 1'b0; bmode = 1'b1; settle();
    chk_enh("R11 direct off", 5'b0);

    // R10 R11: parallel control write, bits 3 and 5
    bmode = 1'b0; smode = 1'b0; settle();
    chk_enh("R1 parallel keeps enh", 5'b11111);
    pdata = 8'h28; settle();
    strb[1] = 1'b1; settle();
    chk_enh("R10 par rise load", 5'b00101);
    strb[1] = 1'b0; settle();
    chk_enh("R10 par fall no shadow", 5'b00101);
    pdata = 8'h07; settle();
    pulse(1);
    chk_enh("R11 reserved bits silent", 5'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule